// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the two wires of an I2C bus without ever driving them. It samples SCL and SDA in the system clock domain and reports what it sees. It gives a one-cycle pulse for a first START, for a repeated START and for a STOP. It keeps a level that says whether the bus is owned by some master. It also flags SDA transitions during the SCL high phase that cannot be part of a legal transfer.

In a multi-master system, a master that wants the bus first checks the busy level, and a bus arbiter can log the condition pulses. The monitor counts SCL rising edges within each byte. On the ninth edge it gives a pulse for the acknowledge slot, together with the level seen on SDA, so that software-independent logic can follow ACK and NACK traffic. It also counts the bytes completed since the last START.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, busy_o is 0, byte_cnt_o is 0, and no pulse output is high until the lines change.
- R2: When the bus is free and SDA falls while SCL stays high, start_o pulses for exactly one cycle and busy_o becomes 1. Both lines idle high.
- R3: When the bus is busy and SDA falls while SCL stays high, rstart_o pulses for one cycle instead of start_o, and busy_o stays 1.
- R4: When the bus is busy and SDA rises while SCL stays high, stop_o pulses for one cycle and busy_o becomes 0. busy_o then stays 0, however SCL toggles, until the next START.
- R5: While busy, the ninth SCL rising edge after a START or repeated START, and every ninth edge after that, produces a one-cycle slot_o pulse. In the same cycle, nack_o takes the SDA level at that edge (0 = ACK, 1 = NACK) and holds it until the next slot.
- R6: byte_cnt_o increments on every slot_o pulse, saturates at its all-ones value, and returns to 0 on every START or repeated START.
- R7: An SDA change seen in the same sample as an SCL change is not a condition: it produces no start, repeated-start, stop or violation pulse.
- R8: A START- or STOP-shaped event while the bus is busy and the bit position is 2 to 8 pulses viol_o. The event is still reported as a repeated START or STOP. The bit position counts SCL rising edges since the last START, 1 to 9 and then wrapping to 1.
- R9: A STOP-shaped event while the bus is free pulses viol_o and does not pulse stop_o.
- R10: With SYNC_STAGES = 2, a condition pulse appears at the third rising clock edge after the line change is driven, and lasts for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| start_o | output | 1 | Pulse: START seen on a free bus |
| rstart_o | output | 1 | Pulse: START seen on a busy bus |
| stop_o | output | 1 | Pulse: STOP ending a busy period |
| busy_o | output | 1 | Bus owned by some master |
| viol_o | output | 1 | Pulse: illegal SDA change while SCL high |
| slot_o | output | 1 | Pulse: acknowledge slot sampled |
| nack_o | output | 1 | Level at the last slot, 1 = NACK |
| byte_cnt_o | output | CNT_W | Bytes completed since the last START |

## Verification
The single-cycle pulse properties assume that the lines stay unchanged for at least two system clocks between transitions. This means SCL and SDA are far slower than clk, which is true for any real bus. Every bench task holds each line level for several clocks, so no two synchronized edges ever fall in neighbouring samples. The bench deliberately changes both lines together only in the R7 scenario, and there it waits out the same hold time.

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             start_o,
  output logic             rstart_o,
  output logic             stop_o,
  output logic             busy_o,
  output logic             viol_o,
  output logic             slot_o,
  output logic             nack_o,
  output logic [CNT_W-1:0] byte_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [3:0] LAST_BIT = 4'd9;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic [3:0] bit_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  wire scl_s     = scl_sh[SYNC_STAGES-1];
  wire sda_s     = sda_sh[SYNC_STAGES-1];
  wire scl_high  = scl_s & scl_q;
  wire scl_rise  = scl_s & ~scl_q;
  wire cond_st   = scl_high & sda_q & ~sda_s;
  wire cond_sp   = scl_high & ~sda_q & sda_s;
  wire mid_byte  = (bit_pos >= 4'd2) && (bit_pos <= 4'd8);
  wire ack_edge  = scl_rise & busy_o & (bit_pos == LAST_BIT - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o    <= 1'b0;
      rstart_o   <= 1'b0;
      stop_o     <= 1'b0;
      viol_o     <= 1'b0;
      busy_o     <= 1'b0;
      slot_o     <= 1'b0;
      nack_o     <= 1'b0;
      bit_pos    <= '0;
      byte_cnt_o <= '0;
    end else begin
      start_o  <= cond_st & ~busy_o;
      rstart_o <= cond_st & busy_o;
      stop_o   <= cond_sp & busy_o;
      viol_o   <= (cond_sp & ~busy_o) | ((cond_st | cond_sp) & busy_o & mid_byte);
      slot_o   <= ack_edge;

      if (cond_st)      busy_o <= 1'b1;
      else if (cond_sp) busy_o <= 1'b0;

      if (cond_st | cond_sp)
        bit_pos <= '0;
      else if (scl_rise & busy_o)
        bit_pos <= (bit_pos == LAST_BIT) ? 4'd1 : bit_pos + 4'd1;

      if (ack_edge) nack_o <= sda_s;

      if (cond_st)
        byte_cnt_o <= '0;
      else if (ack_edge && byte_cnt_o != CNT_MAX)
        byte_cnt_o <= byte_cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_o,
  input logic             rstart_o,
  input logic             stop_o,
  input logic             busy_o,
  input logic             viol_o,
  input logic             slot_o,
  input logic [CNT_W-1:0] byte_cnt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!busy_o && !start_o && !stop_o && !viol_o && byte_cnt_o == '0);
    end
  end

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (busy_o && !$past(busy_o)));

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  assert_rstart_keeps_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_o |-> (busy_o && $past(busy_o)));

  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!busy_o && $past(busy_o)));

  assert_busy_only_by_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (start_o || rstart_o));

  assert_slot_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o |-> $past(busy_o));

  assert_count_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o |-> byte_cnt_o != '0);

  assert_count_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || rstart_o) |-> byte_cnt_o == '0);

  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, rstart_o, stop_o}));

  assert_free_viol_no_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && !$past(busy_o)) |-> !stop_o);

endmodule

bind i2c_bus_watch i2c_bus_watch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_o(start_o), .rstart_o(rstart_o),
  .stop_o(stop_o), .busy_o(busy_o), .viol_o(viol_o), .slot_o(slot_o),
  .byte_cnt_o(byte_cnt_o)
);

// File: tb/sim_i2c_bus_watch.sv
`timescale 1ns/1ps
module sim_i2c_bus_watch;
  localparam int CW = 3;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic start_o, rstart_o, stop_o, busy_o, viol_o, slot_o, nack_o;
  logic [CW-1:0] byte_cnt_o;
  int checks = 0, fails = 0;
  int n_st = 0, n_rs = 0, n_sp = 0, n_vi = 0, n_sl = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_bus_watch #(.SYNC_STAGES(2), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .busy_o(busy_o),
    .viol_o(viol_o), .slot_o(slot_o), .nack_o(nack_o), .byte_cnt_o(byte_cnt_o));

  always @(negedge clk) if (rst_n) begin
    n_st += int'(start_o); n_rs += int'(rstart_o); n_sp += int'(stop_o);
    n_vi += int'(viol_o);  n_sl += int'(slot_o);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic d);
    @(negedge clk); scl = s; sda = d;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    put(1'b0, b); put(1'b1, b); put(1'b0, b);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ack);
  endtask

  task automatic do_rstart();
    put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0); put(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 byte count", byte_cnt_o, 0);
    chk("R1 pulses", n_st + n_rs + n_sp + n_vi + n_sl, 0);
  endtask

  task automatic t_start_latency();
    @(negedge clk); sda = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 no pulse at edge 2", start_o, 0);
    @(negedge clk);
    chk("R10 pulse at edge 3", start_o, 1);
    chk("R2 busy set", busy_o, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", start_o, 0);
    repeat (H) @(negedge clk);
    put(1'b0, 1'b0);
    chk("R2 single start", n_st, 1);
  endtask

  task automatic t_bytes();
    send_byte(8'hA5, 1'b0);
    chk("R5 slot count", n_sl, 1);
    chk("R5 ack", nack_o, 0);
    chk("R6 count 1", byte_cnt_o, 1);
    send_byte(8'h3C, 1'b1);
    chk("R5 slot count 2", n_sl, 2);
    chk("R5 nack", nack_o, 1);
    chk("R6 count 2", byte_cnt_o, 2);
  endtask

  task automatic t_rstart();
    do_rstart();
    chk("R3 rstart", n_rs, 1);
    chk("R3 no start", n_st, 1);
    chk("R3 busy kept", busy_o, 1);
    chk("R6 cleared", byte_cnt_o, 0);
    chk("R8 legal rstart no viol", n_vi, 0);
  endtask

  task automatic t_stop_idle();
    do_stop();
    chk("R4 stop", n_sp, 1);
    chk("R4 busy clear", busy_o, 0);
    for (int i = 0; i < 9; i++) begin put(1'b0, 1'b1); put(1'b1, 1'b1); end
    chk("R4 stays free", busy_o, 0);
    chk("R4 no slot while free", n_sl, 2);
  endtask

  task automatic t_simul();
    int c;
    c = n_st + n_rs + n_sp + n_vi;
    put(1'b0, 1'b0);
    put(1'b1, 1'b1);
    chk("R7 no events", n_st + n_rs + n_sp + n_vi, c);
    chk("R7 still free", busy_o, 0);
  endtask

  task automatic t_stray_stop();
    put(1'b0, 1'b1); put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
    chk("R9 viol", n_vi, 1);
    chk("R9 no stop", n_sp, 1);
  endtask

  task automatic t_midbyte();
    put(1'b1, 1'b0); put(1'b0, 1'b0);
    chk("R2 second start", n_st, 2);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_rstart();
    chk("R8 viol mid byte", n_vi, 2);
    chk("R8 rstart reported", n_rs, 2);
    do_stop();
    chk("R8 legal stop no viol", n_vi, 2);
    chk("R4 stop 2", n_sp, 2);
  endtask

  task automatic t_saturate();
    put(1'b1, 1'b0); put(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(8'(i * 37), 1'b0);
    chk("R6 saturate", byte_cnt_o, 7);
    chk("R5 slots", n_sl, 10);
    do_stop();
    chk("R4 final free", busy_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_start_latency();
    t_bytes();
    t_rstart();
    t_stop_idle();
    t_simul();
    t_stray_stop();
    t_midbyte();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule